// File: doc/BRIEF.md
# 16-bit Effective Address Generator

This unit turns the addressing byte of an instruction into a memory operand address for 16-bit code. It decodes the two-bit mode field and three-bit register/memory field, adds the selected base and index register values and an optional displacement, wraps the sum to 16 bits and then adds a 20-bit segment base to form the linear address. It also reports how many displacement bytes the form consumed, so the fetch logic can advance past them.

The default segment follows the addressing form: forms built on BP use the stack base, all others the data base. A segment-override selection, when enabled, replaces the default with one of the four segment bases. An addressing byte whose mode field is 3 names a register operand, and the unit then flags the operand as register-direct and produces no address.

Inputs are sampled on a valid strobe and all results appear registered one cycle later. The 16-bit offset is exported on its own for load-effective-address use.

Top module: `ea16_gen`

## Requirements
- R1: The rm field (bits 2:0 of `modrm`) selects the register sum: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX (rm 6 only when mode is not 0).
- R2: With mode (bits 7:6) equal to 0 and rm equal to 6, the offset is `disp` alone with no register added, the default segment is DS, and the displacement length is 2.
- R3: Mode 1 adds `disp[7:0]` sign-extended to 16 bits and reports length 1; mode 2 adds the full 16-bit `disp` and reports length 2; mode 0 (other than the direct form) adds nothing and reports length 0. `disp_used` is 1 exactly when the length is non-zero.
- R4: Without override, rm 2 and 3, and rm 6 with mode not 0, use `base_ss`; every other memory form uses `base_ds`.
- R5: When `ovr_en` is 1, `ovr_sel` picks the base regardless of form: 0 `base_es`, 1 `base_cs`, 2 `base_ss`, 3 `base_ds`.
- R6: When mode is 3 (addressing byte 0xC0 or above), `reg_op` is 1 and `ea_off`, `ea_lin`, `disp_len` and `disp_used` are all 0, whatever the override inputs.
- R7: The offset is the register sum plus displacement modulo 2^16; the linear address is the chosen base plus the zero-extended offset modulo 2^20.
- R8: Results appear with `out_valid` high in the cycle after `in_valid` is sampled; `out_valid` is low otherwise and the result outputs hold their last value. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| modrm | input | 8 | Addressing byte |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| disp | input | 16 | Displacement bytes, low byte first in bits 7:0 |
| base_es | input | 20 | ES segment base |
| base_cs | input | 20 | CS segment base |
| base_ss | input | 20 | SS segment base |
| base_ds | input | 20 | DS segment base |
| ovr_en | input | 1 | Segment override active |
| ovr_sel | input | 2 | Override segment: 0 ES, 1 CS, 2 SS, 3 DS |
| out_valid | output | 1 | Result valid |
| ea_off | output | 16 | 16-bit effective offset |
| ea_lin | output | 20 | Linear address |
| disp_used | output | 1 | A displacement was consumed |
| disp_len | output | 2 | Displacement bytes consumed (0, 1, 2) |
| reg_op | output | 1 | Register-direct operand |

## Verification
The bench builds the unit with its default widths, a 16-bit offset and a 20-bit linear address. These widths make both wrap points reachable with small stimuli: register sums and negative byte displacements that cross 2^16, and segment bases near the top of the 20-bit space that carry past 2^20. Every rm value is exercised under all three memory modes, each override selection is applied to forms of both default segments, and register-direct bytes are sent with an override active.

// File: rtl/ea16_gen.sv
module ea16_gen #(
  parameter int OFF_W = 16,
  parameter int LIN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       modrm,
  input  logic [OFF_W-1:0] reg_bx,
  input  logic [OFF_W-1:0] reg_bp,
  input  logic [OFF_W-1:0] reg_si,
  input  logic [OFF_W-1:0] reg_di,
  input  logic [OFF_W-1:0] disp,
  input  logic [LIN_W-1:0] base_es,
  input  logic [LIN_W-1:0] base_cs,
  input  logic [LIN_W-1:0] base_ss,
  input  logic [LIN_W-1:0] base_ds,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  output logic             out_valid,
  output logic [OFF_W-1:0] ea_off,
  output logic [LIN_W-1:0] ea_lin,
  output logic             disp_used,
  output logic [1:0]       disp_len,
  output logic             reg_op
);

  localparam int EXT_W = OFF_W - 8;
  localparam int PAD_W = LIN_W - OFF_W;

  logic [1:0]       md;
  logic [2:0]       rm;
  logic             direct_c;
  logic             is_reg_c;
  logic [OFF_W-1:0] base_r;
  logic [OFF_W-1:0] index_r;
  logic [OFF_W-1:0] dext;
  logic [OFF_W-1:0] off_c;
  logic             use_ss;
  logic [LIN_W-1:0] seg_c;
  logic [LIN_W-1:0] lin_c;
  logic [1:0]       len_c;

  assign md       = modrm[7:6];
  assign rm       = modrm[2:0];
  assign direct_c = (md == 2'd0) && (rm == 3'd6);
  assign is_reg_c = (md == 2'd3);

  always_comb begin
    base_r  = '0;
    index_r = '0;
    case (rm)
      3'd0: begin base_r = reg_bx; index_r = reg_si; end
      3'd1: begin base_r = reg_bx; index_r = reg_di; end
      3'd2: begin base_r = reg_bp; index_r = reg_si; end
      3'd3: begin base_r = reg_bp; index_r = reg_di; end
      3'd4: index_r = reg_si;
      3'd5: index_r = reg_di;
      3'd6: base_r = reg_bp;
      default: base_r = reg_bx;
    endcase
  end

  always_comb begin
    case (md)
      2'd1:    dext = {{EXT_W{disp[7]}}, disp[7:0]};
      2'd2:    dext = disp;
      default: dext = '0;
    endcase
  end

  assign off_c  = direct_c ? disp : (base_r + index_r + dext);
  assign use_ss = !direct_c && ((rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6));

  always_comb begin
    if (ovr_en) begin
      case (ovr_sel)
        2'd0:    seg_c = base_es;
        2'd1:    seg_c = base_cs;
        2'd2:    seg_c = base_ss;
        default: seg_c = base_ds;
      endcase
    end else begin
      seg_c = use_ss ? base_ss : base_ds;
    end
  end

  assign lin_c = seg_c + {{PAD_W{1'b0}}, off_c};

  always_comb begin
    if (is_reg_c)            len_c = 2'd0;
    else if (direct_c)       len_c = 2'd2;
    else if (md == 2'd1)     len_c = 2'd1;
    else if (md == 2'd2)     len_c = 2'd2;
    else                     len_c = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea_off    <= '0;
      ea_lin    <= '0;
      disp_used <= 1'b0;
      disp_len  <= 2'd0;
      reg_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reg_op    <= is_reg_c;
        ea_off    <= is_reg_c ? '0 : off_c;
        ea_lin    <= is_reg_c ? '0 : lin_c;
        disp_used <= !is_reg_c && (md != 2'd0 || rm == 3'd6);
        disp_len  <= len_c;
      end
    end
  end

  p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(ea_off) && $stable(ea_lin)));

  p_direct_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && modrm[7:6] == 2'd0 && modrm[2:0] == 3'd6) |=>
      (ea_off == $past(disp) && disp_len == 2'd2 && !reg_op));

  p_reg_noaddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && reg_op) |-> (ea_off == '0 && ea_lin == '0 && disp_len == 2'd0 && !disp_used));

  p_len_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (disp_used == (disp_len != 2'd0) && disp_len != 2'd3));

  p_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovr_en && ovr_sel == 2'd0 && modrm[7:6] != 2'd3) |=>
      (ea_lin == $past(base_es) + {{PAD_W{1'b0}}, ea_off}));

endmodule

// File: tb/ea16_gen_tb.sv
module ea16_gen_tb;
  localparam int OFF_W = 16;
  localparam int LIN_W = 20;

  typedef struct {
    logic [OFF_W-1:0] off;
    logic [LIN_W-1:0] lin;
    logic             used;
    logic [1:0]       len;
    logic             rop;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] modrm = '0;
  logic [OFF_W-1:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, disp = '0;
  logic [LIN_W-1:0] base_es = '0, base_cs = '0, base_ss = '0, base_ds = '0;
  logic ovr_en = 1'b0;
  logic [1:0] ovr_sel = '0;
  logic out_valid, disp_used, reg_op;
  logic [OFF_W-1:0] ea_off;
  logic [LIN_W-1:0] ea_lin;
  logic [1:0] disp_len;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t sb[$];
  exp_t last;

  always #4 clk = ~clk;

  ea16_gen #(.OFF_W(OFF_W), .LIN_W(LIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm(modrm),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp(disp), .base_es(base_es), .base_cs(base_cs), .base_ss(base_ss),
    .base_ds(base_ds), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .out_valid(out_valid), .ea_off(ea_off), .ea_lin(ea_lin),
    .disp_used(disp_used), .disp_len(disp_len), .reg_op(reg_op));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [7:0] b, input string tag);
    exp_t e;
    logic [OFF_W-1:0] s;
    logic [LIN_W-1:0] sg;
    bit ss_def;
    int m;
    int r;
    m = b[7:6];
    r = b[2:0];
    e.tag = tag;
    if (m == 3) begin
      e.off = 0; e.lin = 0; e.used = 0; e.len = 0; e.rop = 1;
      return e;
    end
    e.rop = 0;
    if (m == 0 && r == 6) begin
      s = disp; ss_def = 0; e.len = 2;
    end else begin
      case (r)
        0: s = reg_bx + reg_si;
        1: s = reg_bx + reg_di;
        2: s = reg_bp + reg_si;
        3: s = reg_bp + reg_di;
        4: s = reg_si;
        5: s = reg_di;
        6: s = reg_bp;
        default: s = reg_bx;
      endcase
      ss_def = (r == 2 || r == 3 || r == 6);
      if (m == 1) begin
        s = s + {{8{disp[7]}}, disp[7:0]}; e.len = 1;
      end else if (m == 2) begin
        s = s + disp; e.len = 2;
      end else e.len = 0;
    end
    if (ovr_en) sg = (ovr_sel == 0) ? base_es : (ovr_sel == 1) ? base_cs :
                     (ovr_sel == 2) ? base_ss : base_ds;
    else sg = ss_def ? base_ss : base_ds;
    e.off = s;
    e.lin = sg + {4'h0, s};
    e.used = (e.len != 0);
    return e;
  endfunction

  task automatic send(input logic [7:0] b, input logic [OFF_W-1:0] d,
                      input bit oe, input logic [1:0] os, input string tag);
    modrm = b; disp = d; ovr_en = oe; ovr_sel = os; in_valid = 1'b1;
    sb.push_back(model(b, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R8", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        last = e;
        check(ea_off == e.off, e.tag, "ea_off", 32'(ea_off), 32'(e.off));
        check(ea_lin == e.lin, e.tag, "ea_lin", 32'(ea_lin), 32'(e.lin));
        check(disp_len == e.len && disp_used == e.used, e.tag, "disp_len/used",
              {29'd0, disp_used, disp_len}, {29'd0, e.used, e.len});
        check(reg_op == e.rop, e.tag, "reg_op", 32'(reg_op), 32'(e.rop));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && ea_off == 0 && ea_lin == 0 && disp_len == 0 && !reg_op && !disp_used,
          "R8", "reset state", {ea_lin, ea_off[7:0], 1'b0, out_valid, disp_len}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_bx = 16'h1234; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0004;
    base_ds = 20'h12340; base_ss = 20'h20000; base_es = 20'h30000; base_cs = 20'h40000;

    for (int r = 0; r < 8; r++) send({2'b00, 3'd0, 3'(r)}, 16'h5A5A, 0, 0, (r == 6) ? "R2" : "R1");
    for (int r = 0; r < 8; r++) send({2'b01, 3'd2, 3'(r)}, 16'h0011, 0, 0, "R3");
    for (int r = 0; r < 8; r++) send({2'b10, 3'd5, 3'(r)}, 16'h0400, 0, 0, "R4");
    send(8'h46, 16'h00F0, 0, 0, "R3");
    send(8'h82, 16'hF000, 0, 0, "R3");
    for (int s = 0; s < 4; s++) send(8'h43, 16'h0008, 1, 2'(s), "R5");
    for (int s = 0; s < 4; s++) send(8'h07, 16'h0000, 1, 2'(s), "R5");
    send(8'h06, 16'hBEEF, 1, 2'd2, "R5");
    send(8'hC0, 16'h1234, 0, 0, "R6");
    send(8'hFF, 16'h00FF, 1, 2'd1, "R6");
    send(8'hD6, 16'h0080, 0, 0, "R6");

    reg_bx = 16'hFFF0; reg_si = 16'h0020;
    send(8'h00, 16'h0000, 0, 0, "R7");
    reg_bx = 16'h0010;
    send(8'h47, 16'h0080, 0, 0, "R7");
    base_ds = 20'hFFFF0;
    send(8'h06, 16'h0100, 0, 0, "R7");
    base_ss = 20'hFFF00; reg_bp = 16'hFFFF;
    send(8'h86, 16'h0001, 0, 0, "R7");

    repeat (3) @(negedge clk);
    check(out_valid == 0, "R8", "out_valid idle", 32'(out_valid), 32'd0);
    check(ea_off == last.off && ea_lin == last.lin, "R8", "hold after idle",
          {12'd0, ea_lin}, {12'd0, last.lin});
    check(sb.size() == 0, "R8", "pending results", 32'(sb.size()), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog expired actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule